// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Scan-Line Buffer

This block holds pixel data for a bitmap display between a burst memory reader and the pixel output stage. The reader runs on the system clock. It delivers 32-bit words, one per acknowledged transfer while a fetch is active. The display side runs on the pixel clock and takes out one 8-bit pixel every cycle, without pause, blanking included.

Storage is split into two halves. The parity of the row on screen picks the half that is read. The writer fills the other half, which is why memory data always arrives one row ahead of the display. Inside each stored word the byte order is reversed: pixel column 0 comes from the most significant byte.

The read path has two registers. The bank read is registered once, and the selected byte is registered again before it drives the pixel output.

Top module: `scanline_pingpong_buf`

## Requirements
- R1: While `rst` is high at a rising `pix_clk` edge, `pix_o` becomes 0 at that edge and stays 0.
- R2: A word is stored only when `wr_en` and `wr_ack` are both high at the same rising `sys_clk` edge. With either one low, no stored byte changes.
- R3: A write goes to half `~wr_shown_row_lsb`, at word `wr_col[10:2]`. `wr_col[1:0]` has no effect on where the word lands.
- R4: A read uses half `rd_row_lsb`, word `rd_col[10:2]`. Each half holds 512 words of 32 bits, which is 2048 pixels.
- R5: The byte returned for column c is lane `3 - c[1:0]` of the stored word. So c%4 = 0 gives bits 31:24, 1 gives 23:16, 2 gives 15:8 and 3 gives 7:0.
- R6: Take `rd_row_lsb` and `rd_col` as sampled at `pix_clk` edge n. The pixel they select appears on `pix_o` just after edge n+1. Just after edge n, `pix_o` still shows the previous selection.
- R7: A write into one half never changes the other half. A write into one half and reads of the other half can run in the same cycles, and both give correct results.
- R8: The read side has no enable. A new column on every `pix_clk` cycle produces a new pixel on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Write-side (memory fetch) clock |
| pix_clk | input | 1 | Read-side (pixel) clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Fetch cycle active |
| wr_ack | input | 1 | Transfer acknowledge; with `wr_en`, stores `wr_data` |
| wr_shown_row_lsb | input | 1 | Parity of the row currently displayed, as seen by the writer |
| wr_col | input | 11 | Pixel column of the first byte of the word being written |
| wr_data | input | 32 | Word from memory |
| rd_row_lsb | input | 1 | Parity of the displayed row |
| rd_col | input | 11 | Pixel column to show |
| pix_o | output | 8 | Registered pixel output |

## Verification
Two things can happen in the same cycle: a fill write into one half and a pixel read from the other half. To provoke this, the bench writes a word into the fill half while it steps the read column through the shown half on every pixel clock, in parallel. It then judges the result twice. Every streamed pixel must match the shown half's earlier contents with the two-register delay. A later read of the fill half must return the new word with its bytes reversed.

// File: rtl/lb_pkg.sv
package lb_pkg;

    // Default geometry of the buffer
    localparam int unsigned PIX_BITS  = 8;
    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned COL_BITS  = 11;

    // Identity of a buffer half
    typedef enum logic {
        HALF_EVEN = 1'b0,
        HALF_ODD  = 1'b1
    } half_e;

    // Half that the display reads for a row of the given parity
    function automatic half_e show_half(input logic row_lsb);
        return half_e'(row_lsb);
    endfunction

    // Half that the fetcher fills while the given row parity is shown
    function automatic half_e fill_half(input logic shown_row_lsb);
        return half_e'(~shown_row_lsb);
    endfunction

endpackage

// File: rtl/lb_wr_port.sv
module lb_wr_port
    import lb_pkg::*;
#(
    parameter int unsigned COL_W  = COL_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned PIX_W  = PIX_BITS,
    localparam int unsigned LANES  = DATA_W / PIX_W,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned ADDR_W = 1 + COL_W - LANE_W
) (
    input  logic              wr_en,
    input  logic              wr_ack,
    input  logic              shown_row_lsb,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);

    half_e target;

    always_comb begin
        target = fill_half(shown_row_lsb);
        we     = wr_en & wr_ack;
        waddr  = {target, col[COL_W-1:LANE_W]};
        wdata  = data;
    end

endmodule

// File: rtl/lb_bank_array.sv
module lb_bank_array
    import lb_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned PIX_W  = PIX_BITS,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned LANES  = DATA_W / PIX_W,
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    // One byte-wide bank per lane; written together, read together
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [PIX_W-1:0] mem [DEPTH];
        logic [PIX_W-1:0] q;

        always_ff @(posedge wclk) begin
            if (we) begin
                mem[waddr] <= wdata[ln*PIX_W +: PIX_W];
            end
        end

        always_ff @(posedge rclk) begin
            q <= mem[raddr];
        end

        assign rdata[ln*PIX_W +: PIX_W] = q;
    end

endmodule

// File: rtl/lb_rd_port.sv
module lb_rd_port
    import lb_pkg::*;
#(
    parameter int unsigned COL_W  = COL_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned PIX_W  = PIX_BITS,
    localparam int unsigned LANES  = DATA_W / PIX_W,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned ADDR_W = 1 + COL_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_lsb,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PIX_W-1:0]  pix
);

    half_e             src;
    logic [LANE_W-1:0] lane_d;
    logic [LANE_W-1:0] lane_q;
    logic [LANES-1:0]  lane_hot;
    logic [PIX_W-1:0]  pix_d;

    always_comb begin
        src    = show_half(row_lsb);
        raddr  = {src, col[COL_W-1:LANE_W]};
        // byte order within a word is reversed: lowest column -> top lane
        lane_d = LANE_W'(LANES - 1) - col[LANE_W-1:0];
    end

    // Lane choice travels alongside the bank read
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_dec
        assign lane_hot[ln] = (lane_q == LANE_W'(ln));
    end

    always_comb begin
        pix_d = '0;
        for (int ln = 0; ln < LANES; ln++) begin
            pix_d = pix_d | (rdata[ln*PIX_W +: PIX_W] & {PIX_W{lane_hot[ln]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
        end else begin
            pix <= pix_d;
        end
    end

    // R5
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(lane_hot));

    // R5
    lane_reverse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lane_q + $past(col[LANE_W-1:0]) == LANE_W'(LANES - 1)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pix == '0));

endmodule

// File: rtl/scanline_pingpong_buf.sv
module scanline_pingpong_buf
    import lb_pkg::*;
#(
    parameter int unsigned COL_W  = COL_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned PIX_W  = PIX_BITS,
    localparam int unsigned LANES  = DATA_W / PIX_W,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned ADDR_W = 1 + COL_W - LANE_W
) (
    input  logic              sys_clk,
    input  logic              pix_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ack,
    input  logic              wr_shown_row_lsb,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_row_lsb,
    input  logic [COL_W-1:0]  rd_col,
    output logic [PIX_W-1:0]  pix_o
);

    logic              we_w;
    logic [ADDR_W-1:0] waddr_w;
    logic [DATA_W-1:0] wdata_w;
    logic [ADDR_W-1:0] raddr_w;
    logic [DATA_W-1:0] rdata_w;

    lb_wr_port #(.COL_W(COL_W), .DATA_W(DATA_W), .PIX_W(PIX_W)) u_wr (
        .wr_en        (wr_en),
        .wr_ack       (wr_ack),
        .shown_row_lsb(wr_shown_row_lsb),
        .col          (wr_col),
        .data         (wr_data),
        .we           (we_w),
        .waddr        (waddr_w),
        .wdata        (wdata_w)
    );

    lb_bank_array #(.DATA_W(DATA_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk (sys_clk),
        .we   (we_w),
        .waddr(waddr_w),
        .wdata(wdata_w),
        .rclk (pix_clk),
        .raddr(raddr_w),
        .rdata(rdata_w)
    );

    lb_rd_port #(.COL_W(COL_W), .DATA_W(DATA_W), .PIX_W(PIX_W)) u_rd (
        .clk    (pix_clk),
        .rst    (rst),
        .row_lsb(rd_row_lsb),
        .col    (rd_col),
        .rdata  (rdata_w),
        .raddr  (raddr_w),
        .pix    (pix_o)
    );

    // R2
    write_gate_chk: assert property (@(posedge sys_clk) disable iff (rst)
        we_w |-> (wr_en && wr_ack));

    // R3
    fill_half_chk: assert property (@(posedge sys_clk) disable iff (rst)
        we_w |-> (waddr_w[ADDR_W-1] != wr_shown_row_lsb));

    // R3
    fill_word_chk: assert property (@(posedge sys_clk) disable iff (rst)
        we_w |-> (waddr_w[ADDR_W-2:0] == wr_col[COL_W-1:LANE_W]));

    // R4
    show_half_chk: assert property (@(posedge pix_clk) disable iff (rst)
        raddr_w[ADDR_W-1] == rd_row_lsb);

endmodule

// File: tb/scanline_pingpong_buf_test.sv
module scanline_pingpong_buf_test;

    logic        sys_clk = 1'b0;
    logic        pix_clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_ack = 1'b0;
    logic        wr_row = 1'b0;
    logic [10:0] wr_col = '0;
    logic [31:0] wr_data = '0;
    logic        rd_row = 1'b0;
    logic [10:0] rd_col = '0;
    logic [7:0]  pix;

    int checks = 0;
    int fails  = 0;

    always #4 sys_clk = ~sys_clk;   // 125 MHz
    always #5 pix_clk = ~pix_clk;

    scanline_pingpong_buf uut (
        .sys_clk         (sys_clk),
        .pix_clk         (pix_clk),
        .rst             (rst),
        .wr_en           (wr_en),
        .wr_ack          (wr_ack),
        .wr_shown_row_lsb(wr_row),
        .wr_col          (wr_col),
        .wr_data         (wr_data),
        .rd_row_lsb      (rd_row),
        .rd_col          (rd_col),
        .pix_o           (pix)
    );

    // {shown row parity, column, word}
    localparam logic [43:0] VEC [6] = '{
        {1'b0, 11'd0,    32'hA1B2C3D4},
        {1'b0, 11'd7,    32'h55667788},
        {1'b0, 11'd2047, 32'hDEADBEEF},
        {1'b1, 11'd0,    32'h0F1E2D3C},
        {1'b1, 11'd1364, 32'h9A8B7C6D},
        {1'b1, 11'd2046, 32'hCAFEF00D}
    };

    function automatic logic [7:0] byte_at(input logic [31:0] w, input logic [1:0] c);
        case (c)
            2'd0:    return w[31:24];
            2'd1:    return w[23:16];
            2'd2:    return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic row, input logic [10:0] col, input logic [31:0] d,
                           input logic en, input logic ack);
        @(negedge sys_clk);
        wr_row = row; wr_col = col; wr_data = d; wr_en = en; wr_ack = ack;
        @(negedge sys_clk);
        wr_en = 1'b0; wr_ack = 1'b0;
    endtask

    task automatic rd_pix(input logic row, input logic [10:0] col, output logic [7:0] v);
        @(negedge pix_clk);
        rd_row = row; rd_col = col;
        @(posedge pix_clk);
        @(posedge pix_clk);
        #2 v = pix;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;

        // R1: reset state
        repeat (3) @(posedge pix_clk);
        #2 check("R1 reset", pix, 8'h00);
        @(negedge pix_clk); rst = 1'b0;

        // Table: write one row ahead, read it back as the shown row (R3 R4 R5)
        for (int i = 0; i < 6; i++) begin
            wr_word(VEC[i][43], VEC[i][42:32], VEC[i][31:0], 1'b1, 1'b1);
            for (int k = 0; k < 4; k++) begin
                rd_pix(~VEC[i][43], {VEC[i][42:34], 2'(k)}, v);
                check("R3/R4/R5 table", v, byte_at(VEC[i][31:0], 2'(k)));
            end
        end

        // R7: half 0 word 0 was written later; half 1 word 0 unchanged
        rd_pix(1'b1, 11'd0, v); check("R7 other half kept", v, 8'hA1);
        rd_pix(1'b0, 11'd0, v); check("R7 own half", v, 8'h0F);

        // R2: en without ack, ack without en
        wr_word(1'b0, 11'd0, 32'hFFFFFFFF, 1'b1, 1'b0);
        wr_word(1'b0, 11'd0, 32'hEEEEEEEE, 1'b0, 1'b1);
        rd_pix(1'b1, 11'd0, v); check("R2 no write", v, 8'hA1);
        rd_pix(1'b1, 11'd3, v); check("R2 no write", v, 8'hD4);

        // R6/R8: new column every cycle, pixel one edge behind the sample edge
        for (int k = 0; k < 5; k++) begin
            @(negedge pix_clk);
            rd_row = 1'b1; rd_col = (k < 4) ? 11'(k) : 11'd0;
            @(posedge pix_clk);
            #2;
            if (k >= 1) check("R6/R8 stream", pix, byte_at(32'hA1B2C3D4, 2'(k - 1)));
        end

        // R7: fill write and shown-half reads in the same cycles
        fork
            begin
                @(posedge pix_clk);
                wr_word(1'b1, 11'd20, 32'h13579BDF, 1'b1, 1'b1);
            end
            begin
                for (int k = 0; k < 6; k++) begin
                    @(negedge pix_clk);
                    rd_row = 1'b1; rd_col = 11'd4 + 11'(k % 4);
                    @(posedge pix_clk);
                    #2;
                    if (k >= 1) check("R7 concurrent read", pix, byte_at(32'h55667788, 2'((k - 1) % 4)));
                end
            end
        join
        rd_pix(1'b0, 11'd20, v); check("R7 concurrent write", v, 8'h13);
        rd_pix(1'b0, 11'd23, v); check("R7 concurrent write", v, 8'hDF);

        // R1: reset mid-run clears the output
        @(negedge pix_clk); rst = 1'b1; rd_row = 1'b1; rd_col = 11'd0;
        repeat (2) @(posedge pix_clk);
        #2 check("R1 mid-run reset", pix, 8'h00);
        @(negedge pix_clk); rst = 1'b0;
        rd_pix(1'b1, 11'd1, v); check("R1 after reset", v, 8'hB2);

        finish_run();
    end

endmodule